// File: doc/BRIEF.md
# Programmable Prioritized Interrupt Controller

This block gathers sixteen maskable interrupt sources and one non-maskable input and presents the CPU with one summary: the highest priority level that is pending and enabled, which source owns that level, and whether the non-maskable request is active. Each maskable source has its own programmable level from 1 to 15. A level value of 0 keeps the source from ever being reported. When several sources share the top level, the lowest source index wins.

The sources are numbered 0 to 15. Indices 0–5 are external lines, and each one can be set to rising-edge or low-level trigger. Indices 6–9 are external active-low lines with a fixed low-level trigger. Indices 10–13 are on-chip event strobes for the tick timer, the general-purpose timer, the watchdog and the bus-error detector. Indices 14–15 are software interrupts. Every external line, the non-maskable line included, passes through a two-flop synchronizer. An edge-type source keeps a sticky pending bit. Software clears that bit by writing a one to it. While the bit is set, further edges from that source are lost.

A single-cycle register port gives software the level map, the trigger-type selection, the enable mask, the pending status and the software-set bits.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every register reads 0 (levels 0, all external lines in low-level mode, all sources disabled, nothing pending), and irq_req, irq_level, irq_src and nmi_req are 0.
- R2: External lines pass two flops before detection. A level source reads as pending two clock edges after its line goes low. An edge source's pending bit is set on the third edge after its line rises.
- R3: Register TRIG (address 2), bit i (i = 0..5), selects the trigger for source i: 1 means rising edge and 0 means low level. Sources 6–9 are always low-level, whatever TRIG holds.
- R4: Register PEND (address 4), bits 15:0, shows the pending state of each source. Writing 1 to a bit clears a latched edge or software pending bit. Writing 0 has no effect. A level source's bit follows its line and cannot be cleared.
- R5: While an edge pending bit is set, further rising edges of that source are ignored. After the bit is cleared, only a new rising edge sets it again.
- R6: Internal strobes internal_evt[3:0] drive sources 10–13 without synchronization. A rising strobe sets the pending bit on the next clock edge.
- R7: Writing 1 to bit 0 or bit 1 of register SWSET (address 5) sets the pending bit of source 14 or 15. These bits are cleared through PEND like edge bits. SWSET reads as 0.
- R8: Registers LMAP_LO (address 0) and LMAP_HI (address 1) hold a 4-bit level per source. Source i uses bits 4*(i%8)+3:4*(i%8) of the word selected by i/8. irq_level is the largest level among pending, enabled sources with a nonzero level, or 0 if there are none. irq_src names that source, and the lowest index wins a tie.
- R9: ENABLE (address 3), bit i, set to 1 lets source i be reported. A disabled source still shows in PEND but never drives irq_level.
- R10: A rising edge on nmi_line, after synchronization, latches nmi_req. PEND bit 16 shows it and is cleared by writing a 1 to it. While nmi_req is set, irq_src reads 16 and irq_req is 1 regardless of the enable mask. irq_level keeps reporting the maskable result.
- R11: reg_rdata returns, in the same cycle, the contents of the register selected by reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_line | input | 6 | External lines with programmable trigger type (sources 0–5) |
| lowlvl_n | input | 4 | Active-low level lines (sources 6–9) |
| internal_evt | input | 4 | Internal event strobes (sources 10–13) |
| nmi_line | input | 1 | Non-maskable interrupt line, rising edge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | Request to the CPU: NMI or a nonzero maskable level |
| irq_level | output | 4 | Highest pending enabled level, 0 if none |
| irq_src | output | 5 | Winning source index, 16 for NMI |
| nmi_req | output | 1 | Latched non-maskable request |

## Verification
The hardest situation to bring about is a second rising edge that arrives while the first is still latched. The stimulus makes one edge, waits for it to latch, pulses the line again, and then clears the bit. It then checks that PEND reads 0, which shows the second edge left nothing behind, and that only a fresh edge sets the bit again. The priority logic is swept over many pseudo-random combinations of level map, mask and active lines, and the expected winner is computed arithmetically for each one. The trigger-mode switch is covered with the line idle, so a spurious edge from changing the mode would be caught.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC   = 16;
    localparam int LVLW   = 4;
    localparam int NEXT   = 6;
    localparam int NLOW   = 4;
    localparam int NINT   = 4;
    localparam int NSW    = 2;
    localparam int LOW_BASE = NEXT;
    localparam int INT_BASE = NEXT + NLOW;
    localparam int SW_BASE  = NEXT + NLOW + NINT;
    localparam int SRCW   = $clog2(NSRC + 1);
    localparam int NMI_ID = NSRC;
    localparam int DW     = 32;
    localparam int PER_WORD = DW / LVLW;

    typedef enum logic [2:0] {
        RA_LMAP_LO = 3'd0,
        RA_LMAP_HI = 3'd1,
        RA_TRIG    = 3'd2,
        RA_ENABLE  = 3'd3,
        RA_PEND    = 3'd4,
        RA_SWSET   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [LVLW-1:0] level;
        logic [SRCW-1:0] src;
    } irq_win_t;

    // Strictly greater comparison in ascending order keeps the lowest index on ties.
    function automatic irq_win_t pick_winner(input logic [NSRC-1:0] elig,
                                             input logic [NSRC*LVLW-1:0] map);
        irq_win_t w;
        w = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (map[i*LVLW +: LVLW] > w.level)) begin
                w.level = map[i*LVLW +: LVLW];
                w.src   = SRCW'(i);
            end
        end
        return w;
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
    parameter bit PREV_RST = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    input  logic level_mode_i,
    input  logic clr_i,
    input  logic set_i,
    output logic pend_o
);
    logic prev_q, latch_q, rise;

    assign rise = raw_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= PREV_RST;
            latch_q <= 1'b0;
        end else begin
            prev_q <= raw_i;
            if (level_mode_i)
                latch_q <= 1'b0;
            else if (latch_q)
                latch_q <= ~clr_i;
            else if (rise | set_i)
                latch_q <= 1'b1;
        end
    end

    assign pend_o = level_mode_i ? ~raw_i : latch_q;

    // R4: a write-one-to-clear removes a latched edge
    p_w1c_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (latch_q && clr_i && !level_mode_i) |=> !latch_q);

    // R5: a latched edge stays until it is cleared, whatever the line does
    p_sticky_block_r5: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !clr_i && !level_mode_i) |=> latch_q);
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
    import irq_pkg::*;
(
    input  logic [NSRC-1:0]      pend_i,
    input  logic [NSRC-1:0]      enable_i,
    input  logic [NSRC*LVLW-1:0] map_i,
    input  logic                 nmi_i,
    output logic                 irq_req_o,
    output logic [LVLW-1:0]      irq_level_o,
    output logic [SRCW-1:0]      irq_src_o
);
    irq_win_t win;

    always_comb begin
        win         = pick_winner(pend_i & enable_i, map_i);
        irq_level_o = win.level;
        irq_src_o   = nmi_i ? SRCW'(NMI_ID) : win.src;
        irq_req_o   = nmi_i | (win.level != '0);
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NEXT-1:0]   ext_line,
    input  logic [NLOW-1:0]   lowlvl_n,
    input  logic [NINT-1:0]   internal_evt,
    input  logic              nmi_line,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq_req,
    output logic [LVLW-1:0]   irq_level,
    output logic [SRCW-1:0]   irq_src,
    output logic              nmi_req
);
    localparam int NSYNC = NEXT + NLOW + 1;

    logic [NSRC*LVLW-1:0] lmap_q;
    logic [NEXT-1:0]      trig_q;
    logic [NSRC-1:0]      en_q;
    logic                 nmi_q, nmi_prev_q;

    logic [NSYNC-1:0]     sync_in, sync_out;
    logic [NEXT-1:0]      ext_s;
    logic [NLOW-1:0]      low_s;
    logic                 nmi_s;

    logic [NSRC-1:0]      pend_vec;
    logic [NSRC-1:0]      clr_vec;
    logic [NSW-1:0]       sw_set;
    logic                 nmi_clr;
    reg_addr_e            ra;

    assign ra      = reg_addr_e'(reg_addr);
    assign sync_in = {nmi_line, lowlvl_n, ext_line};
    assign ext_s   = sync_out[NEXT-1:0];
    assign low_s   = sync_out[NEXT +: NLOW];
    assign nmi_s   = sync_out[NSYNC-1];

    irq_sync #(.W(NSYNC)) u_sync (
        .clk(clk), .rst(rst), .d_i(sync_in), .q_o(sync_out)
    );

    // Register write side
    always_comb begin
        clr_vec = '0;
        nmi_clr = 1'b0;
        sw_set  = '0;
        if (reg_we && ra == RA_PEND) begin
            clr_vec = reg_wdata[NSRC-1:0];
            nmi_clr = reg_wdata[NSRC];
        end
        if (reg_we && ra == RA_SWSET)
            sw_set = reg_wdata[NSW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lmap_q <= '0;
            trig_q <= '0;
            en_q   <= '0;
        end else if (reg_we) begin
            case (ra)
                RA_LMAP_LO: lmap_q[DW-1:0]             <= reg_wdata;
                RA_LMAP_HI: lmap_q[NSRC*LVLW-1:DW]     <= reg_wdata[NSRC*LVLW-DW-1:0];
                RA_TRIG:    trig_q                     <= reg_wdata[NEXT-1:0];
                RA_ENABLE:  en_q                       <= reg_wdata[NSRC-1:0];
                default: ;
            endcase
        end
    end

    // Source cells
    genvar g;
    generate
        for (g = 0; g < NEXT; g++) begin : g_ext
            irq_src_cell #(.PREV_RST(1'b1)) u_cell (
                .clk(clk), .rst(rst), .raw_i(ext_s[g]),
                .level_mode_i(~trig_q[g]), .clr_i(clr_vec[g]),
                .set_i(1'b0), .pend_o(pend_vec[g])
            );
        end
        for (g = 0; g < NLOW; g++) begin : g_low
            irq_src_cell #(.PREV_RST(1'b1)) u_cell (
                .clk(clk), .rst(rst), .raw_i(low_s[g]),
                .level_mode_i(1'b1), .clr_i(clr_vec[LOW_BASE+g]),
                .set_i(1'b0), .pend_o(pend_vec[LOW_BASE+g])
            );
        end
        for (g = 0; g < NINT; g++) begin : g_int
            irq_src_cell #(.PREV_RST(1'b1)) u_cell (
                .clk(clk), .rst(rst), .raw_i(internal_evt[g]),
                .level_mode_i(1'b0), .clr_i(clr_vec[INT_BASE+g]),
                .set_i(1'b0), .pend_o(pend_vec[INT_BASE+g])
            );
        end
        for (g = 0; g < NSW; g++) begin : g_sw
            irq_src_cell #(.PREV_RST(1'b1)) u_cell (
                .clk(clk), .rst(rst), .raw_i(1'b0),
                .level_mode_i(1'b0), .clr_i(clr_vec[SW_BASE+g]),
                .set_i(sw_set[g]), .pend_o(pend_vec[SW_BASE+g])
            );
        end
    endgenerate

    // Non-maskable input: rising-edge latch, write-one-to-clear
    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev_q <= 1'b1;
            nmi_q      <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_s;
            if (nmi_q)
                nmi_q <= ~nmi_clr;
            else if (nmi_s && !nmi_prev_q)
                nmi_q <= 1'b1;
        end
    end

    assign nmi_req = nmi_q;

    irq_resolve u_resolve (
        .pend_i(pend_vec), .enable_i(en_q), .map_i(lmap_q), .nmi_i(nmi_q),
        .irq_req_o(irq_req), .irq_level_o(irq_level), .irq_src_o(irq_src)
    );

    // Register read side
    always_comb begin
        reg_rdata = '0;
        case (ra)
            RA_LMAP_LO: reg_rdata = lmap_q[DW-1:0];
            RA_LMAP_HI: reg_rdata[NSRC*LVLW-DW-1:0] = lmap_q[NSRC*LVLW-1:DW];
            RA_TRIG:    reg_rdata[NEXT-1:0] = trig_q;
            RA_ENABLE:  reg_rdata[NSRC-1:0] = en_q;
            RA_PEND:    reg_rdata[NSRC:0]   = {nmi_q, pend_vec};
            default:    reg_rdata = '0;
        endcase
    end

    // R10: a synchronized rising edge on the NMI line latches the request
    p_nmi_latch_r10: assert property (@(posedge clk) disable iff (rst)
        (nmi_s && !nmi_prev_q && !nmi_q) |=> nmi_q);

    // R10: the NMI owns the source output while it is latched
    p_nmi_owns_src_r10: assert property (@(posedge clk) disable iff (rst)
        nmi_q |-> (irq_src == SRCW'(NMI_ID) && irq_req));

    // R8, R9: a reported maskable level belongs to a pending, enabled source
    p_winner_eligible_r8: assert property (@(posedge clk) disable iff (rst)
        (!nmi_q && irq_level != '0) |->
            (pend_vec[irq_src[SRCW-2:0]] && en_q[irq_src[SRCW-2:0]]));

    // R4: a PEND write without bit 16 leaves a latched NMI in place
    p_nmi_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (nmi_q && !nmi_clr) |=> nmi_q);
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  ext_line;
    logic [3:0]  lowlvl_n;
    logic [3:0]  internal_evt;
    logic        nmi_line;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [3:0]  irq_level;
    logic [4:0]  irq_src;
    logic        nmi_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst(rst), .ext_line(ext_line), .lowlvl_n(lowlvl_n),
        .internal_evt(internal_evt), .nmi_line(nmi_line), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_level(irq_level), .irq_src(irq_src),
        .nmi_req(nmi_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    logic [31:0] rv;
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        #900000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ext_line = '1; lowlvl_n = '1; internal_evt = '0;
        nmi_line = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), rv);
            chk("R1 reg reset", rv, 32'h0);
        end
        chk("R1 outputs reset", {27'h0, irq_req, irq_level, irq_src != 0, nmi_req}, 32'h0);

        // R11: register readback
        wr(3'd0, 32'hFEDC_BA98); rd(3'd0, rv); chk("R11 LMAP_LO", rv, 32'hFEDC_BA98);
        wr(3'd1, 32'h1357_9BDF); rd(3'd1, rv); chk("R11 LMAP_HI", rv, 32'h1357_9BDF);
        wr(3'd3, 32'hFFFF_A5A5); rd(3'd3, rv); chk("R11 ENABLE", rv, 32'h0000_A5A5);
        wr(3'd5, 32'h0);         rd(3'd5, rv); chk("R7 SWSET reads 0", rv, 32'h0);

        // R2: level latency on an active-low line (source 6)
        lowlvl_n[0] = 1'b0;
        tick(1); rd(3'd4, rv); chk("R2 level not yet", rv[6], 1'b0);
        tick(1); rd(3'd4, rv); chk("R2 level after two edges", rv[6], 1'b1);
        // R4: write one to a level bit has no effect
        wr(3'd4, 32'h0000_0040); rd(3'd4, rv); chk("R4 level bit not clearable", rv[6], 1'b1);
        // R3: TRIG cannot change sources 6-9
        wr(3'd2, 32'h0000_03FF); rd(3'd2, rv); chk("R3 TRIG width", rv, 32'h3F);
        tick(1); rd(3'd4, rv); chk("R3 fixed level line", rv[6], 1'b1);
        lowlvl_n[0] = 1'b1;
        wr(3'd2, 32'h0); tick(3);

        // R8, R9: sweep of level map, mask and active level lines (sources 0-9)
        for (int t = 0; t < 300; t++) begin
            logic [31:0] m0, m1, en, act;
            logic [3:0]  best;
            logic [4:0]  bsrc;
            seed = nxt(seed); m0 = seed;
            seed = nxt(seed); m1 = seed;
            seed = nxt(seed); en = seed & 32'hFFFF;
            seed = nxt(seed); act = seed & 32'h3FF;
            if (t % 7 == 0) act = 32'h3FF;
            wr(3'd0, m0); wr(3'd1, m1); wr(3'd3, en);
            ext_line = ~act[5:0];
            lowlvl_n = ~act[9:6];
            tick(3);
            best = 0; bsrc = 0;
            for (int i = 0; i < 16; i++) begin
                logic [3:0] lv;
                lv = (i < 8) ? m0[i*4 +: 4] : m1[(i-8)*4 +: 4];
                if (act[i] && en[i] && lv > best) begin
                    best = lv; bsrc = 5'(i);
                end
            end
            chk("R8 level", {28'h0, irq_level}, {28'h0, best});
            chk("R8 source", {27'h0, irq_src}, {27'h0, bsrc});
            chk("R8 request", {31'h0, irq_req}, {31'h0, best != 0});
            rd(3'd4, rv);
            chk("R9 pend raw", rv, act);
        end
        ext_line = '1; lowlvl_n = '1;
        wr(3'd3, 32'h0); wr(3'd0, 32'h0); wr(3'd1, 32'h0);
        tick(3);

        // R3: switch source 0 to edge with the line idle high, no spurious event
        wr(3'd2, 32'h1); tick(3);
        rd(3'd4, rv); chk("R3 no spurious edge", rv[0], 1'b0);
        // R2: edge latency
        ext_line[0] = 1'b0; tick(2);
        rd(3'd4, rv); chk("R3 low ignored in edge mode", rv[0], 1'b0);
        ext_line[0] = 1'b1;
        tick(2); rd(3'd4, rv); chk("R2 edge not yet", rv[0], 1'b0);
        tick(1); rd(3'd4, rv); chk("R2 edge latched", rv[0], 1'b1);
        // R4: write zero no effect
        wr(3'd4, 32'h0); rd(3'd4, rv); chk("R4 write zero", rv[0], 1'b1);
        // R5: second edge while pending is lost
        ext_line[0] = 1'b0; tick(3); ext_line[0] = 1'b1; tick(4);
        wr(3'd4, 32'h1); tick(2);
        rd(3'd4, rv); chk("R5 lost edge", rv[0], 1'b0);
        rd(3'd4, rv); chk("R4 cleared", rv, 32'h0);
        ext_line[0] = 1'b0; tick(3); ext_line[0] = 1'b1; tick(4);
        rd(3'd4, rv); chk("R5 new edge after clear", rv[0], 1'b1);
        wr(3'd2, 32'h0); tick(1);
        rd(3'd4, rv); chk("R3 back to level", rv[0], 1'b0);

        // R6: internal strobe, source 12
        internal_evt[2] = 1'b1; tick(1);
        rd(3'd4, rv); chk("R6 strobe latched", rv, 32'h0000_1000);
        internal_evt[2] = 1'b0;
        wr(3'd0, 32'h0); wr(3'd1, 32'h7003_0000); wr(3'd3, 32'hFFFF);
        chk("R8 internal level", {28'h0, irq_level}, 32'h3);
        chk("R8 internal src", {27'h0, irq_src}, 32'd12);

        // R7: software source 15 at level 7 wins over 12 at level 3
        wr(3'd5, 32'h2);
        rd(3'd4, rv); chk("R7 sw set", rv, 32'h0000_9000);
        chk("R7 sw level", {28'h0, irq_level}, 32'h7);
        chk("R7 sw src", {27'h0, irq_src}, 32'd15);
        wr(3'd4, 32'h0000_8000);
        rd(3'd4, rv); chk("R7 sw clear", rv, 32'h0000_1000);
        wr(3'd4, 32'h0000_1000);

        // R10: NMI with all sources disabled
        wr(3'd3, 32'h0);
        nmi_line = 1'b1; tick(2);
        chk("R10 nmi not yet", {31'h0, nmi_req}, 32'h0);
        tick(1);
        chk("R10 nmi latched", {31'h0, nmi_req}, 32'h1);
        chk("R10 nmi src", {27'h0, irq_src}, 32'd16);
        chk("R10 nmi req", {31'h0, irq_req}, 32'h1);
        rd(3'd4, rv); chk("R10 pend bit16", rv, 32'h0001_0000);
        wr(3'd4, 32'h0000_FFFF);
        chk("R10 nmi kept", {31'h0, nmi_req}, 32'h1);
        wr(3'd4, 32'h0001_0000);
        chk("R10 nmi cleared", {31'h0, nmi_req}, 32'h0);
        chk("R10 req drops", {31'h0, irq_req}, 32'h0);
        nmi_line = 1'b0;
        tick(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule